// File: doc/BRIEF.md
# SPI Slave-Select Controller

This block owns the chip-select line of an SPI port. When the port is the bus master it drives the select pin. In manual mode the pin follows a software bit. In automatic mode the block raises select when the shift engine is told to start and drops it when each word ends. When the port is a bus slave the pin is an input. The block synchronises it, interprets it against a programmable active polarity, and turns it into an enable for the shift engine. Two interpretations are available: a level interpretation, where the engine is enabled while select is held active, and an edge interpretation, where an active-going transition opens a word that stays open until the engine reports completion.

In level slave mode the block also reports two things. It shows whether the received bit count has reached the programmed word length. As an option, it emits a one-cycle pulse that raises the unit-transfer flag when select returns to its inactive level. The shift engine, the transfer flag register and the FIFOs live outside this block.

Top module: `spi_ssel_ctrl`

## Requirements
- R1: In master mode with automatic select off, the select is active one clock after the software select bit is 1 and inactive one clock after it is 0.
- R2: In master mode with automatic select on, the select goes active one clock after a start pulse. It goes inactive one clock after a word-done pulse, or after busy is low, unless a start pulse arrives in the same cycle, in which case it stays active.
- R3: The active-level bit sets polarity on both sides. When it is 1, the select pin is high when active and low when idle, and a high slave input is active. When it is 0, all of these levels are inverted.
- R4: In slave mode the pin output enable is 0, the select output holds the idle level, and the software select bit, start and busy have no effect on it.
- R5: In level-trigger slave mode, the slave enable equals "synchronised pin equals active level". A pin change becomes visible after the third rising clock edge and not before.
- R6: In edge-trigger slave mode (trigger bit 0), an inactive-to-active transition of the synchronised pin sets the slave enable. The pin returning inactive does not clear it; only a word-done pulse does, and a new transition in the same cycle wins over done.
- R7: The length-met flag is 1 one clock after a cycle in level slave mode where the word length is non-zero and the received bit count is at least the word length. Otherwise it is 0.
- R8: In level slave mode with the inactive-flag option on, an active-to-inactive transition of the synchronised pin gives exactly one cycle of the transfer-flag pulse. In every other mode the pulse never occurs.
- R9: During reset and in the first cycle after it, the select output is at the idle level for the configured polarity, and the slave enable, length flag and pulse are 0.
- R10: In master mode the slave enable, length flag and pulse are 0 and the pin output enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_slave | input | 1 | 1 = slave mode, 0 = master mode |
| cfg_auto_sel | input | 1 | Master: 1 = automatic select per word |
| cfg_sw_sel | input | 1 | Master manual select request |
| cfg_act_high | input | 1 | 1 = select active high / rising edge |
| cfg_level | input | 1 | Slave: 1 = level trigger, 0 = edge trigger |
| cfg_inact_flag | input | 1 | Slave level: pulse transfer flag on deselect |
| cfg_word_len | input | LEN_W | Required word length in bits |
| eng_start | input | 1 | Start pulse from the control logic |
| eng_busy | input | 1 | Shift engine busy |
| eng_done | input | 1 | Word-done pulse from the shift engine |
| rx_bit_cnt | input | LEN_W | Bits received in the current word |
| ss_pin_in | input | 1 | Select pin input (slave mode) |
| ss_pin_out | output | 1 | Select pin drive level |
| ss_pin_oe | output | 1 | Select pin output enable |
| slave_en | output | 1 | Slave shift engine enable |
| len_met | output | 1 | Received bits reached word length |
| xfer_flag_set | output | 1 | One-cycle pulse to set the transfer flag |

## Verification
Assertions check on every cycle the master select response to start, done and the manual bit, the idle drive in slave mode, that the slave outputs stay quiet in master mode, that the edge-mode enable holds until done, and that the deselect pulse lasts a single cycle. Only the bench scenarios can show the exact three-edge latency through the synchroniser, that edge-mode enable survives the pin going inactive, and that the length flag compares against the programmed word length. The same holds for polarity reversal on both pin directions and the reset levels. A behavioural model with its own pin history is compared with every output on every clock.

// File: rtl/ssel_pkg.sv
package ssel_pkg;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;

  // Pin level for a logical select state under a given polarity.
  function automatic logic pin_level(input logic active, input logic act_high);
    return active ? act_high : ~act_high;
  endfunction

endpackage

// File: rtl/ssel_sync.sv
module ssel_sync #(
  parameter int       STAGES  = 2,
  parameter logic     RST_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic sync_q,
  output logic prev_q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = pin;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], pin};
    end
  endgenerate

  always_comb prev_d = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_LVL}};
      prev_q  <= RST_LVL;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign sync_q = chain_q[STAGES-1];

  AST_PREV_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> prev_q == $past(sync_q)); // R5

endmodule

// File: rtl/ssel_master.sv
module ssel_master (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic auto_sel,
  input  logic sw_sel,
  input  logic start,
  input  logic busy,
  input  logic done,
  output logic act_q
);

  logic act_d;

  always_comb begin
    act_d = act_q;
    if (!en) begin
      act_d = 1'b0;
    end else if (!auto_sel) begin
      act_d = sw_sel;
    end else if (start) begin
      act_d = 1'b1;
    end else if (done || !busy) begin
      act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
    end else begin
      act_q <= act_d;
    end
  end

  AST_MANUAL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !auto_sel) |=> act_q == $past(sw_sel)); // R1
  AST_AUTO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (en && auto_sel && start) |=> act_q); // R2
  AST_AUTO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && auto_sel && !start && done) |=> !act_q); // R2
  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !act_q); // R4

endmodule

// File: rtl/ssel_slave.sv
module ssel_slave
  import ssel_pkg::*;
#(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  trig_e            trig,
  input  logic             act_high,
  input  logic             inact_opt,
  input  logic             sync_lvl,
  input  logic             prev_lvl,
  input  logic             done,
  input  logic [LEN_W-1:0] rx_cnt,
  input  logic [LEN_W-1:0] word_len,
  output logic             slave_en_q,
  output logic             len_met_q,
  output logic             inact_q
);

  logic act_now;
  logic act_old;
  logic went_active;
  logic went_idle;
  logic slave_en_d;
  logic len_met_d;
  logic inact_d;
  logic level_mode;

  always_comb begin
    act_now     = (sync_lvl == act_high);
    act_old     = (prev_lvl == act_high);
    went_active = act_now && !act_old;
    went_idle   = !act_now && act_old;
    level_mode  = en && (trig == TRIG_LEVEL);
  end

  always_comb begin
    slave_en_d = slave_en_q;
    if (!en) begin
      slave_en_d = 1'b0;
    end else if (trig == TRIG_LEVEL) begin
      slave_en_d = act_now;
    end else if (went_active) begin
      slave_en_d = 1'b1;
    end else if (done) begin
      slave_en_d = 1'b0;
    end
  end

  always_comb begin
    len_met_d = level_mode && (word_len != '0) && (rx_cnt >= word_len);
    inact_d   = level_mode && inact_opt && went_idle;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slave_en_q <= 1'b0;
      len_met_q  <= 1'b0;
      inact_q    <= 1'b0;
    end else begin
      slave_en_q <= slave_en_d;
      len_met_q  <= len_met_d;
      inact_q    <= inact_d;
    end
  end

  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && trig == TRIG_EDGE && slave_en_q && !done) |=> slave_en_q); // R6
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    inact_q |=> !inact_q); // R8
  AST_LEN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !level_mode |=> !len_met_q); // R7
  AST_EDGE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (trig == TRIG_EDGE) |=> !inact_q); // R8

endmodule

// File: rtl/spi_ssel_ctrl.sv
module spi_ssel_ctrl
  import ssel_pkg::*;
#(
  parameter int   LEN_W       = 6,
  parameter int   SYNC_STAGES = 2,
  parameter logic PIN_RST_LVL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_slave,
  input  logic             cfg_auto_sel,
  input  logic             cfg_sw_sel,
  input  logic             cfg_act_high,
  input  logic             cfg_level,
  input  logic             cfg_inact_flag,
  input  logic [LEN_W-1:0] cfg_word_len,
  input  logic             eng_start,
  input  logic             eng_busy,
  input  logic             eng_done,
  input  logic [LEN_W-1:0] rx_bit_cnt,
  input  logic             ss_pin_in,
  output logic             ss_pin_out,
  output logic             ss_pin_oe,
  output logic             slave_en,
  output logic             len_met,
  output logic             xfer_flag_set
);

  logic  m_act;
  logic  s_sync;
  logic  s_prev;
  trig_e trig;

  always_comb trig = cfg_level ? TRIG_LEVEL : TRIG_EDGE;

  ssel_sync #(
    .STAGES (SYNC_STAGES),
    .RST_LVL(PIN_RST_LVL)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (ss_pin_in),
    .sync_q(s_sync),
    .prev_q(s_prev)
  );

  ssel_master u_master (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (!cfg_slave),
    .auto_sel(cfg_auto_sel),
    .sw_sel  (cfg_sw_sel),
    .start   (eng_start),
    .busy    (eng_busy),
    .done    (eng_done),
    .act_q   (m_act)
  );

  ssel_slave #(
    .LEN_W(LEN_W)
  ) u_slave (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg_slave),
    .trig      (trig),
    .act_high  (cfg_act_high),
    .inact_opt (cfg_inact_flag),
    .sync_lvl  (s_sync),
    .prev_lvl  (s_prev),
    .done      (eng_done),
    .rx_cnt    (rx_bit_cnt),
    .word_len  (cfg_word_len),
    .slave_en_q(slave_en),
    .len_met_q (len_met),
    .inact_q   (xfer_flag_set)
  );

  always_comb begin
    ss_pin_out = pin_level(m_act, cfg_act_high);
    ss_pin_oe  = !cfg_slave;
  end

  AST_SLAVE_IDLE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_slave) && cfg_slave) |-> ss_pin_out == !cfg_act_high); // R4
  AST_MASTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_slave |=> !($past(cfg_slave)) |-> (!slave_en && !len_met && !xfer_flag_set)); // R10

endmodule

// File: tb/spi_ssel_ctrl_test.sv
module spi_ssel_ctrl_test;

  localparam int LW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_slave = 1'b0, cfg_auto_sel = 1'b0, cfg_sw_sel = 1'b0;
  logic cfg_act_high = 1'b0, cfg_level = 1'b0, cfg_inact_flag = 1'b0;
  logic [LW-1:0] cfg_word_len = 6'd8, rx_bit_cnt = '0;
  logic eng_start = 1'b0, eng_busy = 1'b0, eng_done = 1'b0, ss_pin_in = 1'b1;
  logic ss_pin_out, ss_pin_oe, slave_en, len_met, xfer_flag_set;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  bit model_live = 0;
  string tag = "R9";

  // behavioural reference state
  bit pin_hist[$] = '{1'b1, 1'b1, 1'b1};
  bit m_sel = 0, m_en = 0, m_len = 0, m_pulse = 0;

  always #10 clk = ~clk;

  spi_ssel_ctrl #(.LEN_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_slave(cfg_slave), .cfg_auto_sel(cfg_auto_sel),
    .cfg_sw_sel(cfg_sw_sel), .cfg_act_high(cfg_act_high), .cfg_level(cfg_level),
    .cfg_inact_flag(cfg_inact_flag), .cfg_word_len(cfg_word_len),
    .eng_start(eng_start), .eng_busy(eng_busy), .eng_done(eng_done),
    .rx_bit_cnt(rx_bit_cnt), .ss_pin_in(ss_pin_in), .ss_pin_out(ss_pin_out),
    .ss_pin_oe(ss_pin_oe), .slave_en(slave_en), .len_met(len_met),
    .xfer_flag_set(xfer_flag_set));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_hist = '{1'b1, 1'b1, 1'b1};
      m_sel = 0; m_en = 0; m_len = 0; m_pulse = 0;
    end else begin
      bit seen_old, seen_older, on_now, on_before;
      seen_old   = pin_hist[1];
      seen_older = pin_hist[2];
      on_now     = (seen_old == cfg_act_high);
      on_before  = (seen_older == cfg_act_high);
      if (cfg_slave) begin
        m_sel = 0;
        if (cfg_level) begin
          m_en    = on_now;
          m_len   = (cfg_word_len != 0) && (int'(rx_bit_cnt) >= int'(cfg_word_len));
          m_pulse = cfg_inact_flag && on_before && !on_now;
        end else begin
          if (on_now && !on_before) m_en = 1;
          else if (eng_done) m_en = 0;
          m_len = 0; m_pulse = 0;
        end
      end else begin
        m_en = 0; m_len = 0; m_pulse = 0;
        if (!cfg_auto_sel) m_sel = cfg_sw_sel;
        else if (eng_start) m_sel = 1;
        else if (eng_done || !eng_busy) m_sel = 0;
      end
      pin_hist.push_front(ss_pin_in);
      void'(pin_hist.pop_back());
    end
  end

  task automatic check(input string t, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", t, what, act, exp, $time);
    end
  endtask

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (model_live && !finished) begin
      check(tag, "ss_pin_out", ss_pin_out, m_sel ? cfg_act_high : !cfg_act_high);
      check(tag, "ss_pin_oe", ss_pin_oe, !cfg_slave);
      check(tag, "slave_en", slave_en, m_en);
      check(tag, "len_met", len_met, m_len);
      check(tag, "xfer_flag_set", xfer_flag_set, m_pulse);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R9 watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    @(posedge clk);
    model_live = 1;
    step(2);
    tag = "R9";
    check("R9", "reset ss_pin_out idle", ss_pin_out, 1);
    check("R9", "reset slave_en", slave_en, 0);
    rst_n = 1'b1;
    step(1);
    check("R9", "post reset ss_pin_out idle", ss_pin_out, 1);
    check("R10", "master oe", ss_pin_oe, 1);

    // manual select
    tag = "R1";
    cfg_sw_sel = 1; step(1);
    check("R1", "manual active low", ss_pin_out, 0);
    cfg_sw_sel = 0; step(1);
    check("R1", "manual idle", ss_pin_out, 1);
    tag = "R3";
    cfg_act_high = 1; step(1);
    check("R3", "idle level high-active", ss_pin_out, 0);
    cfg_sw_sel = 1; step(1);
    check("R3", "active level high-active", ss_pin_out, 1);
    cfg_sw_sel = 0; cfg_act_high = 0; step(1);

    // automatic select
    tag = "R2";
    cfg_auto_sel = 1; cfg_sw_sel = 1; step(1);
    check("R2", "auto ignores sw bit", ss_pin_out, 1);
    eng_start = 1; eng_busy = 1; step(1);
    eng_start = 0;
    check("R2", "auto active after start", ss_pin_out, 0);
    step(3);
    check("R2", "auto held during word", ss_pin_out, 0);
    eng_done = 1; eng_start = 1; step(1);
    eng_start = 0; eng_done = 0;
    check("R2", "start wins over done", ss_pin_out, 0);
    eng_done = 1; step(1);
    eng_done = 0;
    check("R2", "inactive after done", ss_pin_out, 1);
    eng_start = 1; step(1); eng_start = 0;
    eng_busy = 0; step(1);
    check("R2", "inactive when busy drops", ss_pin_out, 1);
    cfg_auto_sel = 0; cfg_sw_sel = 0; step(1);

    // slave mode, level trigger, active low
    tag = "R4";
    cfg_slave = 1; cfg_level = 1; cfg_sw_sel = 1; eng_busy = 1; step(1);
    check("R4", "slave oe off", ss_pin_oe, 0);
    check("R4", "slave drives idle", ss_pin_out, 1);
    eng_start = 1; step(1); eng_start = 0;
    check("R4", "start ignored in slave", ss_pin_out, 1);
    cfg_sw_sel = 0; eng_busy = 0;
    tag = "R5";
    ss_pin_in = 0; step(2);
    check("R5", "not visible after two edges", slave_en, 0);
    step(1);
    check("R5", "visible after third edge", slave_en, 1);
    tag = "R7";
    rx_bit_cnt = 6'd7; step(1);
    check("R7", "below length", len_met, 0);
    rx_bit_cnt = 6'd8; step(1);
    check("R7", "at length", len_met, 1);
    cfg_word_len = 6'd32; step(1);
    check("R7", "new length not met", len_met, 0);
    cfg_word_len = 6'd0; rx_bit_cnt = 6'd40; step(1);
    check("R7", "zero length never met", len_met, 0);
    cfg_word_len = 6'd8; rx_bit_cnt = 0;
    tag = "R8";
    cfg_inact_flag = 1; ss_pin_in = 1; step(3);
    check("R8", "deselect pulse", xfer_flag_set, 1);
    check("R5", "level enable drops", slave_en, 0);
    step(1);
    check("R8", "pulse one cycle", xfer_flag_set, 0);
    cfg_inact_flag = 0; ss_pin_in = 0; step(4);
    ss_pin_in = 1; step(3);
    check("R8", "no pulse with option off", xfer_flag_set, 0);

    // slave mode, edge trigger
    tag = "R6";
    cfg_level = 0; cfg_inact_flag = 1; step(2);
    ss_pin_in = 0; step(3);
    check("R6", "falling edge opens word", slave_en, 1);
    ss_pin_in = 1; step(4);
    check("R6", "deselect does not clear", slave_en, 1);
    check("R8", "no pulse in edge mode", xfer_flag_set, 0);
    eng_done = 1; step(1); eng_done = 0;
    check("R6", "done clears", slave_en, 0);
    tag = "R3";
    cfg_act_high = 1; ss_pin_in = 0; step(4);
    eng_done = 1; step(1); eng_done = 0;
    ss_pin_in = 1; step(2);
    check("R3", "rising edge not yet seen", slave_en, 0);
    step(1);
    check("R3", "rising edge opens word", slave_en, 1);
    check("R3", "slave idle drive low", ss_pin_out, 0);

    // back to master: slave outputs quiet
    tag = "R10";
    cfg_slave = 0; step(2);
    check("R10", "master slave_en off", slave_en, 0);
    check("R10", "master oe on", ss_pin_oe, 1);
    step(2);
    finish_run();
  end

endmodule